// File: doc/BRIEF.md
# Paged boot-swap memory decoder

This block generates chip selects for an 8051-class microcontroller that has more memory than its 64 KB address space can reach. It watches the 16-bit address bus, the program-fetch strobe and the data read and write strobes. It drives one-hot selects for eight 16 KB main flash sectors, two 8 KB boot ROM blocks and one system RAM / control-register window. Two registers inside that window steer the decode. The first is a page register that picks which flash sector appears in the paged window. The second is a swap bit that chooses between boot mode and run mode.

In boot mode the processor executes from the boot ROM. Main flash is also visible to data cycles, so firmware can program a new image. Setting the swap bit moves the decoder to run mode. Flash then replaces the boot ROM at the bottom of program space and answers program fetches only. The lower 32 KB is common and decodes the same way for every page value. A flag marks accesses to the two flash command addresses.

The mode is held by a two-state machine. The states are MODE_BOOT and MODE_RUN. Its transitions are SWAP_SET, which is a data write of 1 to the swap register while in MODE_BOOT, and SWAP_CLEAR, which is a data write of 0 while in MODE_RUN. Any other cycle holds the current state.

Top module: `bootswap_decoder`

## Requirements
- R1: After reset the decoder is in boot mode (swap bit 0) and the page register holds 0.
- R2: In boot mode, a program fetch to 0000h-1FFFh raises boot_sel[0], and a program fetch to 2000h-3FFFh raises boot_sel[1].
- R3: In run mode, a program fetch to 0000h-3FFFh raises flash_sel[0], and boot_sel stays 0 in every cycle.
- R4: A program fetch to 4000h-7FFFh raises flash_sel[1] for every page value in both modes. In boot mode a data read or write to the same range does the same.
- R5: A program fetch to 8000h-BFFFh raises flash_sel[p], where p is the page register. In boot mode a data read or write to the same range does the same.
- R6: In run mode, a data read or write anywhere from 2000h to FFFFh raises no select, so writes into flash regions are ignored.
- R7: A data read or write to 0000h-1FFFh raises sysram_sel for every page value and in both modes.
- R8: A data write to 1FF0h loads the page register from wdata[2:0]. A data write to 1FF1h loads the swap bit from wdata[0] (0 = boot, 1 = run). The new value steers the decode from the next rising clock edge.
- R9: flash_cmd is 1 exactly when some flash select is active and addr[14:0] is 5555h or 2AAAh. This covers 5555h, AAAAh and 2AAAh.
- R10: At most one select is active in any cycle. With no strobe active, and for a program fetch to C000h-FFFFh or a data access to 2000h-3FFFh, no select is active.
- R11: When the program-fetch strobe and a data strobe are both active, the cycle decodes as a program fetch, and a data write in that cycle changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_stb | input | 1 | Program-fetch strobe, active high |
| data_rd | input | 1 | Data read strobe, active high |
| data_wr | input | 1 | Data write strobe, active high |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Data bus during writes |
| flash_sel | output | 8 | One-hot main flash sector selects |
| boot_sel | output | 2 | One-hot boot ROM block selects |
| sysram_sel | output | 1 | System RAM / control-register window select |
| flash_cmd | output | 1 | Flash command address flag |

## Verification
All selects and flash_cmd are combinational functions of the address, the strobes and the two registers. They are due in the same cycle as the stimulus. The bench therefore applies each pattern just after a falling edge and samples 2 ns later, with no rising edge in between. A register write is held across one rising edge and released at the next falling edge, so its effect (R8) is checked from that point on. The check just before the write still sees the old page or mode. The sweeps cover every page in both modes, both ends of every 256-byte block, and every strobe combination. Expected values come from an arithmetic address map in the bench.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic {
        MODE_BOOT = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;

    // Region boundaries (exclusive upper ends)
    localparam logic [15:0] RAM_END    = 16'h2000;
    localparam logic [15:0] BOOT_SPLIT = 16'h2000;
    localparam logic [15:0] LOW_END    = 16'h4000;
    localparam logic [15:0] COMMON_END = 16'h8000;
    localparam logic [15:0] PAGED_END  = 16'hC000;

    // Control registers inside the RAM window
    localparam logic [15:0] PAGE_REG_ADDR = 16'h1FF0;
    localparam logic [15:0] SWAP_REG_ADDR = 16'h1FF1;

    // Flash command addresses as seen on the low 15 address lines
    localparam logic [14:0] CMD_ADDR_A = 15'h5555;
    localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;

endpackage

// File: rtl/bsd_mode_fsm.sv
module bsd_mode_fsm
    import bsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_wr,
    input  logic swap_val,
    output logic run_mode
);

    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BOOT: if (swap_wr && swap_val)  state_d = MODE_RUN;   // SWAP_SET
            MODE_RUN:  if (swap_wr && !swap_val) state_d = MODE_BOOT;  // SWAP_CLEAR
            default:   state_d = MODE_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_BOOT: run_mode = 1'b0;
            MODE_RUN:  run_mode = 1'b1;
            default:   run_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsd_page_reg.sv
module bsd_page_reg #(
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_in,
    output logic [PAGE_W-1:0] page_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       page_q <= '0;
        else if (page_wr) page_q <= page_in;
    end

endmodule

// File: rtl/bsd_region_decode.sv
module bsd_region_decode
    import bsd_pkg::*;
#(
    parameter int PAGE_W      = 3,
    parameter int N_BOOT      = 2,
    parameter int VECTOR_SECT = 0,
    parameter int COMMON_SECT = 1
) (
    input  logic [15:0]          addr,
    input  logic                 is_fetch,
    input  logic                 is_data,
    input  logic                 run_mode,
    input  logic [PAGE_W-1:0]    page,
    output logic [(1<<PAGE_W)-1:0] flash_sel,
    output logic [N_BOOT-1:0]    boot_sel,
    output logic                 ram_sel
);

    localparam int N_SECT = 1 << PAGE_W;

    logic              flash_hit;
    logic [PAGE_W-1:0] flash_idx;
    logic              boot_hit;
    logic              boot_idx;

    always_comb begin
        flash_hit = 1'b0;
        flash_idx = '0;
        boot_hit  = 1'b0;
        boot_idx  = (addr >= BOOT_SPLIT);
        ram_sel   = 1'b0;
        if (is_fetch) begin
            if (addr < LOW_END) begin
                if (run_mode) begin
                    flash_hit = 1'b1;
                    flash_idx = PAGE_W'(VECTOR_SECT);
                end else begin
                    boot_hit = 1'b1;
                end
            end else if (addr < COMMON_END) begin
                flash_hit = 1'b1;
                flash_idx = PAGE_W'(COMMON_SECT);
            end else if (addr < PAGED_END) begin
                flash_hit = 1'b1;
                flash_idx = page;
            end
        end else if (is_data) begin
            if (addr < RAM_END) begin
                ram_sel = 1'b1;
            end else if (!run_mode) begin
                if (addr >= LOW_END && addr < COMMON_END) begin
                    flash_hit = 1'b1;
                    flash_idx = PAGE_W'(COMMON_SECT);
                end else if (addr >= COMMON_END && addr < PAGED_END) begin
                    flash_hit = 1'b1;
                    flash_idx = page;
                end
            end
        end
    end

    generate
        for (genvar s = 0; s < N_SECT; s++) begin : g_flash
            assign flash_sel[s] = flash_hit && (flash_idx == PAGE_W'(s));
        end
        for (genvar b = 0; b < N_BOOT; b++) begin : g_boot
            assign boot_sel[b] = boot_hit && (int'(boot_idx) == b);
        end
    endgenerate

endmodule

// File: rtl/bootswap_decoder.sv
module bootswap_decoder
    import bsd_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int N_BOOT = 2,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_stb,
    input  logic                     data_rd,
    input  logic                     data_wr,
    input  logic [15:0]              addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [(1<<PAGE_W)-1:0]   flash_sel,
    output logic [N_BOOT-1:0]        boot_sel,
    output logic                     sysram_sel,
    output logic                     flash_cmd
);

    logic              is_data;
    logic              data_write;
    logic              run_mode;
    logic [PAGE_W-1:0] page_q;

    // Program fetch has priority over data strobes
    assign is_data    = !prog_stb && (data_rd || data_wr);
    assign data_write = !prog_stb && data_wr;

    bsd_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_wr  (data_write && (addr == SWAP_REG_ADDR)),
        .swap_val (wdata[0]),
        .run_mode (run_mode)
    );

    bsd_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .page_wr (data_write && (addr == PAGE_REG_ADDR)),
        .page_in (wdata[PAGE_W-1:0]),
        .page_q  (page_q)
    );

    bsd_region_decode #(.PAGE_W(PAGE_W), .N_BOOT(N_BOOT)) u_dec (
        .addr      (addr),
        .is_fetch  (prog_stb),
        .is_data   (is_data),
        .run_mode  (run_mode),
        .page      (page_q),
        .flash_sel (flash_sel),
        .boot_sel  (boot_sel),
        .ram_sel   (sysram_sel)
    );

    assign flash_cmd = (|flash_sel) &&
                       ((addr[14:0] == CMD_ADDR_A) || (addr[14:0] == CMD_ADDR_B));

endmodule

// File: rtl/bootswap_decoder_chk.sv
module bootswap_decoder_chk #(
    parameter int PAGE_W = 3,
    parameter int N_BOOT = 2,
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   prog_stb,
    input logic                   data_rd,
    input logic                   data_wr,
    input logic [15:0]            addr,
    input logic [DATA_W-1:0]      wdata,
    input logic [(1<<PAGE_W)-1:0] flash_sel,
    input logic [N_BOOT-1:0]      boot_sel,
    input logic                   sysram_sel,
    input logic                   flash_cmd,
    input logic                   run_mode,
    input logic [PAGE_W-1:0]      page_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!run_mode && page_q == '0));

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_sel, boot_sel, sysram_sel}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_stb || data_rd || data_wr) |->
            (flash_sel == '0 && boot_sel == '0 && !sysram_sel));

    // R3
    run_no_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |-> boot_sel == '0);

    // R6
    run_data_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && !prog_stb && (data_rd || data_wr)) |-> flash_sel == '0);

    // R7
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_stb && (data_rd || data_wr) && addr < 16'h2000) |-> sysram_sel);

    // R8
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_stb && data_wr && addr == 16'h1FF0) |=>
            page_q == $past(wdata[PAGE_W-1:0]));

    // R9
    cmd_needs_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cmd |-> flash_sel != '0);

endmodule

bind bootswap_decoder bootswap_decoder_chk #(
    .PAGE_W(PAGE_W), .N_BOOT(N_BOOT), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_stb(prog_stb), .data_rd(data_rd),
    .data_wr(data_wr), .addr(addr), .wdata(wdata), .flash_sel(flash_sel),
    .boot_sel(boot_sel), .sysram_sel(sysram_sel), .flash_cmd(flash_cmd),
    .run_mode(run_mode), .page_q(page_q)
);

// File: tb/bootswap_decoder_tb.sv
`timescale 1ns/1ps
module bootswap_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_stb = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  flash_sel;
    logic [1:0]  boot_sel;
    logic        sysram_sel, flash_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side model of the two registers
    bit m_run = 1'b0;
    int m_page = 0;

    always #4 clk = ~clk;

    bootswap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .prog_stb(prog_stb), .data_rd(data_rd),
        .data_wr(data_wr), .addr(addr), .wdata(wdata), .flash_sel(flash_sel),
        .boot_sel(boot_sel), .sysram_sel(sysram_sel), .flash_cmd(flash_cmd)
    );

    // Expected {cmd, ram, boot[1:0], flash[7:0]} from the address map
    function automatic logic [11:0] model(bit run, int page, int a, bit p, bit r, bit w);
        logic [7:0] fl = '0;
        logic [1:0] bt = '0;
        logic ram = 1'b0;
        logic cmd;
        int low15;
        if (p) begin
            if (a < 'h4000) begin
                if (run) fl[0] = 1'b1;
                else if (a < 'h2000) bt[0] = 1'b1;
                else bt[1] = 1'b1;
            end else if (a < 'h8000) fl[1] = 1'b1;
            else if (a < 'hC000) fl[page] = 1'b1;
        end else if (r || w) begin
            if (a < 'h2000) ram = 1'b1;
            else if (!run) begin
                if (a >= 'h4000 && a < 'h8000) fl[1] = 1'b1;
                else if (a >= 'h8000 && a < 'hC000) fl[page] = 1'b1;
            end
        end
        low15 = a % 'h8000;
        cmd = (fl != 0) && (low15 == 'h5555 || low15 == 'h2AAA);
        return {cmd, ram, bt, fl};
    endfunction

    task automatic apply_check(string tag, int a, bit p, bit r, bit w);
        logic [11:0] exp_v, got;
        @(negedge clk);
        addr = 16'(a); prog_stb = p; data_rd = r; data_wr = w; wdata = 8'h00;
        #2;
        got = {flash_cmd, sysram_sel, boot_sel, flash_sel};
        exp_v = model(m_run, m_page, a, p, r, w);
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h p=%0b r=%0b w=%0b run=%0b page=%0d got=%h exp=%h",
                     tag, a, p, r, w, m_run, m_page, got, exp_v);
        end
    endtask

    // Data write held across one rising edge (R8)
    task automatic reg_write(int a, int d, bit with_fetch);
        @(negedge clk);
        addr = 16'(a); wdata = 8'(d); prog_stb = with_fetch; data_rd = 1'b0; data_wr = 1'b1;
        @(negedge clk);
        prog_stb = 1'b0; data_wr = 1'b0;
        if (!with_fetch) begin
            if (a == 'h1FF0) m_page = d % 8;
            if (a == 'h1FF1) m_run = d[0];
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through selects
        apply_check("R1 boot after reset", 'h0000, 1, 0, 0);
        apply_check("R1 page zero after reset", 'h8000, 1, 0, 0);
        apply_check("R10 idle", 'h0000, 0, 0, 0);

        // R8: old page visible until write, new page afterwards
        reg_write('h1FF0, 5, 0);
        apply_check("R8 page loaded", 'h9000, 1, 0, 0);
        // R11: write with fetch active is ignored
        reg_write('h1FF0, 3, 1);
        apply_check("R11 write ignored under fetch", 'h9000, 1, 0, 0);
        reg_write('h1FF1, 1, 1);
        apply_check("R11 swap ignored under fetch", 'h0000, 1, 0, 0);

        // Sweeps: both modes, every page, block edges, all strobe patterns
        for (int m = 0; m < 2; m++) begin
            reg_write('h1FF1, m, 0);
            apply_check("R8 swap loaded", 'h0100, 1, 0, 0);
            for (int pg = 0; pg < 8; pg++) begin
                reg_write('h1FF0, pg, 0);
                for (int blk = 0; blk < 256; blk++) begin
                    for (int e = 0; e < 2; e++) begin
                        int a = blk * 256 + e * 'hFF;
                        apply_check("R2/R3/R4/R5 fetch", a, 1, 0, 0);
                        apply_check("R6/R7 data read", a, 0, 1, 0);
                        apply_check("R6/R7 data write", a, 0, 0, 1);
                        apply_check("R10 no strobe", a, 0, 0, 0);
                        apply_check("R11 fetch priority", a, 1, 1, 0);
                    end
                end
                // R9: command addresses
                apply_check("R9 cmd 5555 fetch", 'h5555, 1, 0, 0);
                apply_check("R9 cmd AAAA fetch", 'hAAAA, 1, 0, 0);
                apply_check("R9 cmd 2AAA fetch", 'h2AAA, 1, 0, 0);
                apply_check("R9 cmd 5555 write", 'h5555, 0, 0, 1);
                apply_check("R9 cmd AAAA write", 'hAAAA, 0, 0, 1);
                apply_check("R9 non-cmd", 'h5556, 1, 0, 0);
            end
        end

        // R6: flash write in run mode, then page still as set
        apply_check("R6 run write ignored", 'h8000, 0, 0, 1);
        apply_check("R5 page held", 'h8000, 1, 0, 0);
        // Back to boot mode (SWAP_CLEAR)
        reg_write('h1FF1, 0, 0);
        apply_check("R2 boot restored", 'h3000, 1, 0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule